// File: doc/BRIEF.md
# GPIO Bank with Per-Line Edge Interrupts

This block is a bank of up to 32 general-purpose I/O lines, grouped as four 8-bit ports, that sits behind a simple single-cycle register bus with byte strobes. Each line has a direction bit, an output data bit and a function-select bit. The function-select bit is only brought out to the pin-mux logic around the block. Reading the data register returns the synchronized pin level for lines set as inputs and the stored output value for lines set as outputs.

Every input pin passes through a two-flop synchronizer. A per-line 2-bit trigger code picks one of four behaviours for the line: ignored, falling edge, rising edge or both edges. That single field both enables the line and sets its polarity. A qualifying edge sets a sticky flag in a status register, which software clears by writing ones. The single interrupt output is high while any flag is set.

The 32-bit bus word is big-endian with respect to ports. The byte at the lowest address of a register belongs to port 0 (lines 7..0) and is carried on data bits [31:24] and strobe bit 3. Port 3 (lines 31..24) is on bits [7:0] and strobe bit 0.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register reads zero, and pin_oe_o, pin_o, pin_fsel_o and irq_o are all zero.
- R2: In the one-bit-per-line registers, port k (lines 8k+7..8k) is carried on word bits [31-8k:24-8k] and written only when strobe bit 3-k is high. Unstrobed bytes keep their value.
- R3: Direction register at byte offset 0x08 and output register at 0x0C: a direction bit of 1 drives the line's pin_oe_o high and puts its output bit on pin_o. A direction bit of 0 makes the line an input. Neither register changes without a write to it.
- R4: The function-select register at offset 0x00 reads back what was written, and each of its bits appears on pin_fsel_o for its own line (1 = line handed to a dedicated peripheral).
- R5: A line whose trigger code is 00 never sets its status flag, whatever its pin does.
- R6: Trigger codes: 01 sets the flag on a falling edge, 10 on a rising edge, 11 on either edge. The flag is set on the third rising clock edge after the pin changes, counting from the first edge that samples the new level.
- R7: The status register at offset 0x10 uses the R2 byte layout. Writing a 1 to a bit clears it. A 0 bit or an unstrobed byte leaves the bit unchanged.
- R8: If a qualifying edge and a clear write reach the same status bit on the same clock edge, the bit remains set.
- R9: irq_o is high exactly when at least one status flag is set, and it falls only after a write to the status register.
- R10: Reading offset 0x0C returns, for each line, the output register bit if the line is an output, and otherwise the pin level delayed by two clock edges.
- R11: Trigger codes sit at 0x14 (ports 0 and 1) and 0x18 (ports 2 and 3). Each port has a 16-bit field at 0x14 + 2×port. The even port's field occupies word bits [31:16] and the odd port's field bits [15:0]. Line p of a port uses field bits [2p+1:2p].
- R12: Offsets 0x04 and 0x1C, and any address with nonzero low two bits, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address within the bank |
| bus_be_i | input | 4 | Byte strobes, bit 3 = bits [31:24] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read request |
| pin_i | input | NUM_LINES | Pin levels, asynchronous |
| pin_o | output | NUM_LINES | Output values |
| pin_oe_o | output | NUM_LINES | Output enables |
| pin_fsel_o | output | NUM_LINES | Peripheral function select per line |
| irq_o | output | 1 | Level interrupt, OR of all status flags |

## Verification
The properties assume that bus_req_i, bus_we_i, the address and the strobes are clean at each sampling edge. Pin inputs may change at any time, since the synchronizer absorbs them. The bench changes pins and bus signals one time unit after a rising edge and holds every bus request for exactly one cycle. Pin changes are placed with enough idle cycles between them that each edge reaches the status register on its own. The one exception is the same-edge set/clear case, where a clear write is timed to land on the edge that records a new event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int unsigned MAX_LINES = 32;
  localparam int unsigned PORT_W    = 8;
  localparam int unsigned NUM_PORTS = MAX_LINES / PORT_W;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned LANES     = BUS_W / 8;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned TRIG_W    = 2;

  // word index = byte address [4:2]
  typedef enum logic [2:0] {
    REG_FSEL    = 3'd0,
    REG_HOLE    = 3'd1,
    REG_DIR     = 3'd2,
    REG_DATA    = 3'd3,
    REG_STAT    = 3'd4,
    REG_TRIG_LO = 3'd5,
    REG_TRIG_HI = 3'd6,
    REG_END     = 3'd7
  } reg_sel_e;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  // line vector <-> bus word: port 0 lands in the top byte
  function automatic logic [BUS_W-1:0] port_swap(input logic [BUS_W-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      r[BUS_W-1-PORT_W*k -: PORT_W] = v[PORT_W*k +: PORT_W];
    end
    return r;
  endfunction

  // two 16-bit trigger fields <-> bus word: even port in the upper half
  function automatic logic [BUS_W-1:0] half_swap(input logic [BUS_W-1:0] v);
    return {v[BUS_W/2-1:0], v[BUS_W-1:BUS_W/2]};
  endfunction

  function automatic logic [BUS_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[8*i +: 8] = {8{be[i]}};
    end
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] byte_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [LANES-1:0] be);
    logic [BUS_W-1:0] m;
    m = lane_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [TRIG_W*MAX_LINES-1:0] pair_spread(input logic [MAX_LINES-1:0] v);
    logic [TRIG_W*MAX_LINES-1:0] r;
    for (int i = 0; i < MAX_LINES; i++) begin
      r[TRIG_W*i +: TRIG_W] = {TRIG_W{v[i]}};
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [WIDTH-1:0]        level_i,
  input  logic [TRIG_W*WIDTH-1:0] trig_i,
  input  logic [WIDTH-1:0]        clr_i,
  output logic [WIDTH-1:0]        status_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar l = 0; l < WIDTH; l++) begin : g_line
    trig_e code;
    logic  rise, fall;
    assign code    = trig_e'(trig_i[TRIG_W*l +: TRIG_W]);
    assign rise    = level_i[l] & ~prev_q[l];
    assign fall    = ~level_i[l] & prev_q[l];
    assign hit[l]  = (rise && (code == TRIG_RISE || code == TRIG_BOTH)) ||
                     (fall && (code == TRIG_FALL || code == TRIG_BOTH));
    assign en[l]   = (code != TRIG_OFF);
  end

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit;
  end

  assign status_o = status_q;

  p_off_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en)) == '0));

  p_event_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

  p_clear_takes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_q & $past(clr_i & ~hit)) == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter logic [MAX_LINES-1:0] IMPL = '1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [LANES-1:0]            be_i,
  input  logic [BUS_W-1:0]            wdata_i,
  output logic [BUS_W-1:0]            rdata_o,
  input  logic [MAX_LINES-1:0]        level_i,
  input  logic [MAX_LINES-1:0]        status_i,
  output logic [MAX_LINES-1:0]        fsel_o,
  output logic [MAX_LINES-1:0]        dir_o,
  output logic [MAX_LINES-1:0]        dout_o,
  output logic [TRIG_W*MAX_LINES-1:0] trig_o,
  output logic [MAX_LINES-1:0]        clr_o
);

  localparam logic [TRIG_W*MAX_LINES-1:0] TRIG_IMPL = pair_spread(IMPL);
  localparam int unsigned HALF = TRIG_W * MAX_LINES / 2;

  reg_sel_e                    sel;
  logic                        aligned, wr, rd;
  logic [MAX_LINES-1:0]        fsel_q, dir_q, dout_q;
  logic [TRIG_W*MAX_LINES-1:0] trig_q;
  logic [MAX_LINES-1:0]        data_view;

  assign sel     = reg_sel_e'(addr_i[4:2]);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i & aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      trig_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_FSEL: fsel_q <= port_swap(byte_merge(port_swap(fsel_q), wdata_i, be_i)) & IMPL;
        REG_DIR:  dir_q  <= port_swap(byte_merge(port_swap(dir_q), wdata_i, be_i)) & IMPL;
        REG_DATA: dout_q <= port_swap(byte_merge(port_swap(dout_q), wdata_i, be_i)) & IMPL;
        REG_TRIG_LO:
          trig_q[HALF-1:0] <= half_swap(byte_merge(half_swap(trig_q[HALF-1:0]), wdata_i, be_i))
                              & TRIG_IMPL[HALF-1:0];
        REG_TRIG_HI:
          trig_q[2*HALF-1:HALF] <= half_swap(byte_merge(half_swap(trig_q[2*HALF-1:HALF]),
                                                        wdata_i, be_i))
                                   & TRIG_IMPL[2*HALF-1:HALF];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr && sel == REG_STAT) clr_o = port_swap(wdata_i & lane_mask(be_i)) & IMPL;
  end

  assign data_view = (dir_q & dout_q) | (~dir_q & level_i & IMPL);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (sel)
        REG_FSEL:    rdata_o = port_swap(fsel_q);
        REG_DIR:     rdata_o = port_swap(dir_q);
        REG_DATA:    rdata_o = port_swap(data_view);
        REG_STAT:    rdata_o = port_swap(status_i);
        REG_TRIG_LO: rdata_o = half_swap(trig_q[HALF-1:0]);
        REG_TRIG_HI: rdata_o = half_swap(trig_q[2*HALF-1:HALF]);
        default:     rdata_o = '0;
      endcase
    end
  end

  assign fsel_o = fsel_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign trig_o = trig_q;

  p_dout_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == REG_DATA) |=> $stable(dout_q));

  p_dir_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == REG_DIR) |=> $stable(dir_q));

  p_trig_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (sel == REG_TRIG_LO || sel == REG_TRIG_HI)) |=> $stable(trig_q));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [LANES-1:0]     bus_be_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic [NUM_LINES-1:0] pin_fsel_o,
  output logic                 irq_o
);

  localparam logic [MAX_LINES-1:0] IMPL =
    (NUM_LINES >= MAX_LINES) ? '1 : ((32'd1 << NUM_LINES) - 32'd1);

  logic [NUM_LINES-1:0]        level_n;
  logic [MAX_LINES-1:0]        level;
  logic [MAX_LINES-1:0]        status, clr, fsel, dir, dout;
  logic [TRIG_W*MAX_LINES-1:0] trig;

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (level_n)
  );

  always_comb begin
    level = '0;
    level[NUM_LINES-1:0] = level_n;
  end

  gpio_regs #(.IMPL(IMPL)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .level_i  (level),
    .status_i (status),
    .fsel_o   (fsel),
    .dir_o    (dir),
    .dout_o   (dout),
    .trig_o   (trig),
    .clr_o    (clr)
  );

  gpio_edge_status #(.WIDTH(MAX_LINES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .trig_i   (trig),
    .clr_i    (clr),
    .status_o (status)
  );

  assign irq_o      = |status;
  assign pin_o      = dout[NUM_LINES-1:0];
  assign pin_oe_o   = dir[NUM_LINES-1:0];
  assign pin_fsel_o = fsel[NUM_LINES-1:0];

  p_irq_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(bus_req_i && bus_we_i && bus_addr_i == 5'h10));

endmodule

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pout, poe, pfsel;
  logic        irq;

  always #4 clk = ~clk;

  gpio_edge_bank #(.NUM_LINES(N)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_req_i   (req),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_be_i    (be),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pin_i       (pins),
    .pin_o       (pout),
    .pin_oe_o    (poe),
    .pin_fsel_o  (pfsel),
    .irq_o       (irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    tick(1);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    sbq.push_back('{exp: exp, tag: tag});
    req = 1'b1; we = 1'b0; addr = a; be = '0;
    tick(1);
    req = 1'b0;
  endtask

  // monitor: read data is valid in the request cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (req && !we) begin
      item_t it;
      if (sbq.size() == 0) begin
        chk(rdata, 32'hx, "scoreboard empty on read");
      end else begin
        it = sbq.pop_front();
        chk(rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(5'h00, 32'h0, "R1 fsel");
    rd(5'h08, 32'h0, "R1 dir");
    rd(5'h0C, 32'h0, "R1 data");
    rd(5'h10, 32'h0, "R1 status");
    rd(5'h14, 32'h0, "R1 trig lo");
    rd(5'h18, 32'h0, "R1 trig hi");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk(poe, 32'h0, "R1 pin_oe");
    chk(pout, 32'h0, "R1 pin_o");
    chk(pfsel, 32'h0, "R1 pin_fsel");

    // R2 byte lanes, R3 direction and output
    wr(5'h08, 4'b0100, 32'hFFFF_FFFF);
    rd(5'h08, 32'h00FF_0000, "R2 dir single lane");
    chk(poe, 32'h0000_FF00, "R3 oe on port1");
    wr(5'h0C, 4'b1111, 32'h00A5_0000);
    chk(pout, 32'h0000_A500, "R3 pin_o port1");

    // R10 mixed read, R5 no trigger codes
    pins = 32'h5A00_FF3C;
    tick(2);
    rd(5'h0C, 32'h3CA5_005A, "R10 data mix");
    rd(5'h10, 32'h0, "R5 codes off no status");
    chk({31'b0, irq}, 32'h0, "R5 irq low");

    // R10 synchronizer lag
    pins = 32'h5B00_FF3C;
    rd(5'h0C, 32'h3CA5_005A, "R10 lag edge1");
    rd(5'h0C, 32'h3CA5_005A, "R10 lag edge2");
    rd(5'h0C, 32'h3CA5_005B, "R10 synced");

    // R4 function select
    wr(5'h00, 4'b1111, 32'h1234_5678);
    rd(5'h00, 32'h1234_5678, "R4 fsel readback");
    chk(pfsel, 32'h7856_3412, "R4 pin_fsel mapping");

    // R12 holes
    wr(5'h04, 4'b1111, 32'hFFFF_FFFF);
    wr(5'h1C, 4'b1111, 32'hFFFF_FFFF);
    wr(5'h09, 4'b1111, 32'h0);
    rd(5'h04, 32'h0, "R12 hole 0x04");
    rd(5'h1C, 32'h0, "R12 hole 0x1C");
    rd(5'h00, 32'h1234_5678, "R12 fsel untouched");
    rd(5'h08, 32'h00FF_0000, "R12 unaligned write ignored");

    // back to all inputs, quiet pins
    pins = '0;
    wr(5'h08, 4'b1111, 32'h0);
    tick(3);
    rd(5'h10, 32'h0, "R5 status still clear");

    // R6 rising on line 0, R11 field of port 0
    wr(5'h14, 4'b0100, 32'h0002_0000);
    rd(5'h14, 32'h0002_0000, "R11 trig port0 line0");
    pins[0] = 1'b1;
    tick(2);
    chk({31'b0, irq}, 32'h0, "R6 not yet set");
    tick(1);
    chk({31'b0, irq}, 32'h1, "R9 irq on rise");
    rd(5'h10, 32'h0100_0000, "R6 rise status");
    wr(5'h10, 4'b1111, 32'h0100_0000);
    rd(5'h10, 32'h0, "R7 w1c clears");
    chk({31'b0, irq}, 32'h0, "R9 irq low after clear");
    pins[0] = 1'b0;
    tick(3);
    rd(5'h10, 32'h0, "R6 rise mode ignores fall");

    // R6 falling on line 9, R11 field of port 1
    wr(5'h14, 4'b0001, 32'h0000_0004);
    rd(5'h14, 32'h0002_0004, "R11 trig port1 line1 merged");
    pins[9] = 1'b1;
    tick(3);
    rd(5'h10, 32'h0, "R6 fall mode ignores rise");
    pins[9] = 1'b0;
    tick(3);
    rd(5'h10, 32'h0002_0000, "R6 fall status");
    chk({31'b0, irq}, 32'h1, "R9 irq on fall");
    wr(5'h10, 4'b1111, 32'h0);
    rd(5'h10, 32'h0002_0000, "R7 zero write keeps");
    wr(5'h10, 4'b1011, 32'hFFFF_FFFF);
    rd(5'h10, 32'h0002_0000, "R7 unstrobed lane keeps");
    wr(5'h10, 4'b0100, 32'h0002_0000);
    rd(5'h10, 32'h0, "R7 strobed clear");

    // R6 both edges on line 31, R5 line 16 left off, R11 port 3 field
    wr(5'h18, 4'b0010, 32'h0000_C000);
    rd(5'h18, 32'h0000_C000, "R11 trig port3 line7");
    pins[16] = 1'b1;
    pins[31] = 1'b1;
    tick(3);
    rd(5'h10, 32'h0000_0080, "R6 both rise, R5 line16 off");
    wr(5'h10, 4'b0001, 32'h0000_0080);
    rd(5'h10, 32'h0, "R7 clear port3");
    pins[16] = 1'b0;
    pins[31] = 1'b0;
    tick(3);
    rd(5'h10, 32'h0000_0080, "R6 both fall");

    // R8 event and clear on the same edge
    pins[31] = 1'b1;
    tick(2);
    wr(5'h10, 4'b0001, 32'h0000_0080);
    rd(5'h10, 32'h0000_0080, "R8 set wins over clear");
    chk({31'b0, irq}, 32'h1, "R8 irq stays");
    wr(5'h10, 4'b0001, 32'h0000_0080);
    rd(5'h10, 32'h0, "R7 final clear");
    chk({31'b0, irq}, 32'h0, "R9 irq low at end");

    tick(2);
    if (sbq.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule